// File: doc/BRIEF.md
# Address Codeword Early-Abort Comparator

This block watches the bits of a paging codeword as they arrive one at a time, first bit first, each marked by a one-clock bit strobe. During the address part of an address codeword it counts, for every enabled receiver identity, how many raw received bits differ from that identity's stored address pattern. No error correction is applied before this count. Once every enabled identity has collected more than three mismatches, the codeword cannot be one of ours. The block then raises an abort pulse, and the radio receiver can be switched off for the rest of the codeword.

The bit strobe keeps running while the receiver is off, because bit timing is still tracked. The block counts the remaining bit periods and brings the receiver-enable output back up a programmable number of bit periods before the next codeword boundary. This lead time covers the receiver's settling time, so the radio is ready when the next codeword starts. A start-of-codeword flag on the strobe realigns the internal bit position at any time.

Top module: `aea_top`

## Requirements
- R1: After reset `rx_en_o` is 1, and `abort_o` and `reen_o` are 0.
- R2: A codeword is 32 bit strobes numbered 0 to 31. A strobe with `bit_sof` high is position 0. Every other strobe takes the next position, and position 31 is followed by 0 without needing `bit_sof`.
- R3: Position 0 is the flag bit. A flag of 1 marks a message codeword, which is never compared and never aborted.
- R4: Positions 1 to 18 carry the address. The bit at position p is compared with bit 18-p of each identity pattern, so pattern bit 17 is compared first. Positions 19 to 31 are never compared.
- R5: In an address codeword, `abort_o` pulses for one clock after the strobe of the first address bit at which every enabled identity has more than 3 mismatches. It pulses at most once per codeword.
- R6: An identity whose enable bit is 0 has no effect on the abort decision.
- R7: If no identity is enabled, an address codeword aborts on its flag-bit strobe.
- R8: If any enabled identity ends the address field with 3 or fewer mismatches, no abort occurs.
- R9: When an abort occurs at position p and 31-p is greater than `lead_bits`, `rx_en_o` falls in the same clock as the abort pulse. Otherwise `rx_en_o` stays high for the whole codeword.
- R10: After the receiver has been switched off, `rx_en_o` rises and `reen_o` pulses for one clock after the strobe at position 31-`lead_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe per received bit period |
| bit_sof | input | 1 | With `bit_tick`: this bit is position 0 of a codeword |
| bit_in | input | 1 | Received data bit, valid with `bit_tick` |
| id_en | input | 4 | Enable bit for each identity |
| id_addr | input | 72 | Identity patterns, 18 bits each; identity i in bits [18i+17:18i] |
| lead_bits | input | 5 | Receiver-on lead time in bit periods |
| abort_o | output | 1 | One-clock pulse: no enabled identity can match |
| reen_o | output | 1 | One-clock pulse: receiver re-enabled before the next codeword |
| rx_en_o | output | 1 | Receiver enable request |

## Verification
The bench builds the block with its default parameters: four identities, 18-bit addresses, 32-bit codewords and a threshold of three. With these values the abort position depends on mismatches spread across several identities. Driving `lead_bits` at 0, mid-range and 31 covers re-enabling on the last bit, a normal switch-off window, and an abort that comes too late to switch off. Codewords sent back to back without a start flag, and a start flag that arrives in the middle of a codeword, exercise both wrap-around and realignment of the bit position.

// File: rtl/aea_pkg.sv
package aea_pkg;

    typedef enum logic [1:0] {
        FLD_FLAG = 2'd0,
        FLD_ADDR = 2'd1,
        FLD_TAIL = 2'd2
    } field_e;

    typedef struct packed {
        logic valid;
        logic sof;
        logic data;
    } bit_ev_t;

    function automatic field_e classify(input int pos, input int addr_w);
        if (pos == 0)
            return FLD_FLAG;
        else if (pos <= addr_w)
            return FLD_ADDR;
        else
            return FLD_TAIL;
    endfunction

endpackage

// File: rtl/aea_bit_timer.sv
module aea_bit_timer
    import aea_pkg::*;
#(
    parameter int CW_BITS = 32,
    parameter int ADDR_W  = 18,
    localparam int POS_W  = $clog2(CW_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  bit_ev_t          ev,
    output logic [POS_W-1:0] pos_now,
    output field_e           field
);
    logic [POS_W-1:0] pos_q;

    always_comb begin
        pos_now = ev.sof ? '0 : pos_q;
        field   = classify(int'(pos_now), ADDR_W);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (ev.valid)
            pos_q <= (pos_now == POS_W'(CW_BITS - 1)) ? '0 : pos_now + 1'b1;
    end

    AST_SOF_REALIGN: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.sof) |=> (pos_q == POS_W'(1)));  // R2
endmodule

// File: rtl/aea_id_lane.sv
module aea_id_lane
    import aea_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int CNT_W   = 3,
    parameter int THRESH  = 3,
    parameter int CW_BITS = 32,
    localparam int POS_W  = $clog2(CW_BITS),
    localparam int IDX_W  = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_ev_t           ev,
    input  field_e            field,
    input  logic [POS_W-1:0]  pos_now,
    input  logic [ADDR_W-1:0] pattern,
    output logic              over_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx;
    logic             miss;

    always_comb begin
        idx   = IDX_W'(ADDR_W - int'(pos_now));
        miss  = (field == FLD_ADDR) && (pattern[idx] != ev.data);
        cnt_d = cnt_q;
        if (ev.valid) begin
            if (field == FLD_FLAG)
                cnt_d = '0;
            else if (miss && cnt_q != CNT_MAX)
                cnt_d = cnt_q + 1'b1;
        end
        over_next = cnt_d > CNT_W'(THRESH);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    AST_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
        !(ev.valid && field == FLD_FLAG) |=> (cnt_q >= $past(cnt_q)));  // R4
    AST_TAIL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && field == FLD_TAIL) |=> $stable(cnt_q));  // R4
endmodule

// File: rtl/aea_abort_gate.sv
module aea_abort_gate
    import aea_pkg::*;
#(
    parameter int N_ID    = 4,
    parameter int CW_BITS = 32,
    localparam int POS_W  = $clog2(CW_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  bit_ev_t          ev,
    input  field_e           field,
    input  logic [POS_W-1:0] pos_now,
    input  logic [N_ID-1:0]  over_vec,
    input  logic [N_ID-1:0]  id_en,
    input  logic [POS_W-1:0] lead_bits,
    output logic             abort_o,
    output logic             reen_o,
    output logic             rx_en_o
);
    logic             is_addr_q, aborted_q;
    logic             none_en, all_over, fire_flag, fire_addr, fire;
    logic [POS_W-1:0] remain;

    always_comb begin
        none_en   = (id_en == '0);
        all_over  = &(over_vec | ~id_en);
        fire_flag = ev.valid && field == FLD_FLAG && !ev.data && none_en;
        fire_addr = ev.valid && field == FLD_ADDR && is_addr_q && !aborted_q
                    && !none_en && all_over;
        fire      = fire_flag || fire_addr;
        remain    = POS_W'(CW_BITS - 1) - pos_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            is_addr_q <= 1'b0;
            aborted_q <= 1'b0;
            abort_o   <= 1'b0;
            reen_o    <= 1'b0;
            rx_en_o   <= 1'b1;
        end else begin
            abort_o <= fire;
            reen_o  <= 1'b0;
            if (ev.valid) begin
                if (field == FLD_FLAG) begin
                    is_addr_q <= !ev.data;
                    aborted_q <= fire_flag;
                    rx_en_o   <= 1'b1;
                end else if (fire_addr) begin
                    aborted_q <= 1'b1;
                end
                if (fire && remain > lead_bits) begin
                    rx_en_o <= 1'b0;
                end else if (!rx_en_o && remain == lead_bits) begin
                    rx_en_o <= 1'b1;
                    reen_o  <= 1'b1;
                end
            end
        end
    end

    AST_ABORT_ONCE: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o);  // R5
    AST_ABORT_ADDR_ONLY: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> is_addr_q);  // R3
    AST_OFF_WITH_ABORT: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_en_o) |-> abort_o);  // R9
    AST_REEN_EDGE: assert property (@(posedge clk) disable iff (rst)
        reen_o |-> (rx_en_o && !$past(rx_en_o)));  // R10
endmodule

// File: rtl/aea_top.sv
module aea_top
    import aea_pkg::*;
#(
    parameter int N_ID    = 4,
    parameter int ADDR_W  = 18,
    parameter int CW_BITS = 32,
    parameter int CNT_W   = 3,
    parameter int THRESH  = 3,
    localparam int POS_W  = $clog2(CW_BITS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_tick,
    input  logic                   bit_sof,
    input  logic                   bit_in,
    input  logic [N_ID-1:0]        id_en,
    input  logic [N_ID*ADDR_W-1:0] id_addr,
    input  logic [POS_W-1:0]       lead_bits,
    output logic                   abort_o,
    output logic                   reen_o,
    output logic                   rx_en_o
);
    bit_ev_t          ev;
    logic [POS_W-1:0] pos_now;
    field_e           field;
    logic [N_ID-1:0]  over_vec;

    assign ev = '{valid: bit_tick, sof: bit_sof, data: bit_in};

    aea_bit_timer #(.CW_BITS(CW_BITS), .ADDR_W(ADDR_W)) u_timer (
        .clk(clk), .rst(rst), .ev(ev), .pos_now(pos_now), .field(field)
    );

    for (genvar i = 0; i < N_ID; i++) begin : g_lane
        aea_id_lane #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W), .THRESH(THRESH), .CW_BITS(CW_BITS)
        ) u_lane (
            .clk(clk), .rst(rst), .ev(ev), .field(field), .pos_now(pos_now),
            .pattern(id_addr[i*ADDR_W +: ADDR_W]), .over_next(over_vec[i])
        );
    end

    aea_abort_gate #(.N_ID(N_ID), .CW_BITS(CW_BITS)) u_gate (
        .clk(clk), .rst(rst), .ev(ev), .field(field), .pos_now(pos_now),
        .over_vec(over_vec), .id_en(id_en), .lead_bits(lead_bits),
        .abort_o(abort_o), .reen_o(reen_o), .rx_en_o(rx_en_o)
    );
endmodule

// File: tb/tb_aea_top.sv
`timescale 1ns/1ps
module tb_aea_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0, bit_sof = 1'b0, bit_in = 1'b0;
    logic [3:0]  id_en = 4'b0;
    logic [71:0] id_addr = '0;
    logic [4:0]  lead_bits = 5'd0;
    logic        abort_o, reen_o, rx_en_o;

    always #5 clk = ~clk;

    aea_top dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .bit_sof(bit_sof),
        .bit_in(bit_in), .id_en(id_en), .id_addr(id_addr),
        .lead_bits(lead_bits), .abort_o(abort_o), .reen_o(reen_o),
        .rx_en_o(rx_en_o)
    );

    typedef struct { int kind; int tick; string tag; } exp_t;
    exp_t q[$];
    int   checks = 0, errors = 0, tick_id = 0;
    logic [17:0] pat [4];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Expected events from the requirements: kind 0 abort, 1 receiver off, 2 re-enable
    task automatic predict(input logic [31:0] cw, input int base, input string tag);
        int p = -1;
        int mis [4] = '{0, 0, 0, 0};
        if (cw[31] == 1'b0) begin
            if (id_en == 4'b0) p = 0;
            else begin
                for (int k = 1; k <= 18 && p < 0; k++) begin
                    bit all = 1'b1;
                    for (int i = 0; i < 4; i++) begin
                        if (cw[31-k] != pat[i][18-k]) mis[i]++;
                        if (id_en[i] && mis[i] <= 3) all = 1'b0;
                    end
                    if (all) p = k;
                end
            end
        end
        if (p >= 0) begin
            q.push_back('{0, base + p, tag});
            if (31 - p > int'(lead_bits)) begin
                q.push_back('{1, base + p, "R9"});
                q.push_back('{2, base + 31 - int'(lead_bits), "R10"});
            end
        end
    endtask

    task automatic tick(input logic d, input logic sof);
        @(negedge clk);
        tick_id++;
        bit_tick = 1'b1; bit_in = d; bit_sof = sof;
        @(negedge clk);
        bit_tick = 1'b0; bit_sof = 1'b0;
    endtask

    task automatic send_cw(input logic [31:0] cw, input logic sof, input string tag);
        predict(cw, tick_id + 1, tag);
        for (int k = 0; k < 32; k++) tick(cw[31-k], sof && k == 0);
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, tag, q.size(), 0);
        q.delete();
    endtask

    function automatic logic [31:0] mk(input logic flag, input logic [17:0] a);
        return {flag, a, 2'b10, 10'h2D3, 1'b1};
    endfunction

    // Monitor: compare each observed event against the queue head
    logic prev_rx = 1'b1;
    initial begin
        forever begin
            @(posedge clk); #2;
            if (!rst) begin
                if (abort_o) pop_cmp(0);
                if (prev_rx && !rx_en_o) pop_cmp(1);
                if (reen_o) pop_cmp(2);
            end
            prev_rx = rx_en_o;
        end
    end

    task automatic pop_cmp(input int kind);
        exp_t e;
        if (q.size() == 0) begin
            chk(1'b0, "unexpected event", kind, -1);
        end else begin
            e = q.pop_front();
            chk(e.kind == kind, e.tag, kind, e.kind);
            chk(e.tick == tick_id, e.tag, tick_id, e.tick);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pat[0] = 18'h2A5C3; pat[1] = 18'h15A3C; pat[2] = 18'h3F00F; pat[3] = 18'h00FF0;
        for (int i = 0; i < 4; i++) id_addr[i*18 +: 18] = pat[i];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_en_o == 1'b1, "R1 rx_en", rx_en_o, 1);
        chk(abort_o == 1'b0, "R1 abort", abort_o, 0);
        chk(reen_o == 1'b0, "R1 reen", reen_o, 0);

        id_en = 4'b1111; lead_bits = 5'd4;
        send_cw(mk(1'b0, pat[0]), 1'b1, "R8");                       settle("R8 exact");
        send_cw(mk(1'b0, pat[1] ^ 18'h20041), 1'b1, "R8");           settle("R8 three errors");
        send_cw(mk(1'b0, 18'h0A3C5), 1'b1, "R5");                    settle("R5 far");
        send_cw(mk(1'b0, pat[2] ^ 18'h3C000), 1'b1, "R4");           settle("R4 msb first");
        send_cw(mk(1'b1, 18'h0A3C5), 1'b1, "R3");                    settle("R3 message");
        id_en = 4'b1110;
        send_cw(mk(1'b0, pat[0]), 1'b1, "R6");                       settle("R6 disabled");
        id_en = 4'b0000; lead_bits = 5'd20;
        send_cw(mk(1'b0, pat[3]), 1'b1, "R7");                       settle("R7 none enabled");
        id_en = 4'b1111; lead_bits = 5'd31;
        send_cw(mk(1'b0, 18'h0A3C5), 1'b1, "R9");                    settle("R9 late");
        lead_bits = 5'd0;
        send_cw(mk(1'b0, 18'h0A3C5), 1'b1, "R10");                   settle("R10 zero lead");
        lead_bits = 5'd6;
        send_cw(mk(1'b0, pat[3]), 1'b1, "R2");
        send_cw(mk(1'b0, 18'h1C3A5), 1'b0, "R2");                    settle("R2 wrap");
        for (int k = 0; k < 7; k++) tick(1'b1, 1'b0);
        send_cw(mk(1'b0, 18'h0A3C5), 1'b1, "R2");                    settle("R2 realign");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule